// File: doc/BRIEF.md
# Virtual Interrupt Event Bank

This block gathers wide groups of incoming event lines into a small number of virtual interrupt outputs. Each virtual interrupt owns 64 event bits, and each bit is latched into a raw status register. A per-bit enable mask selects which latched bits may raise the virtual interrupt. The output is a level-high line that stays asserted while any enabled status bit is set.

Software reaches each virtual interrupt through its own 4 KiB register page. Enables are never written directly. One offset sets mask bits and another clears them, so drivers can change one bit without a read-modify-write. Each event bit has a mode. A pulse bit stays latched until software writes a one to it in the raw status view. A level bit copies its source and falls when the source drops. Interrupt service code reads the masked view and handles every bit that is set in it.

The access port is a simple request strobe with a write flag, a byte address and 64-bit data. Read data appears one cycle after the read request.

Top module: `vint_bank`

## Requirements
- R1: After reset every enable, raw status and mode bit is 0, every `irq_o` bit is low, and all page reads return 0.
- R2: A write to page offset 0x000 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R3: A write to page offset 0x008 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A read of offset 0x000 or of offset 0x008 returns the current 64-bit enable mask.
- R5: A pulse-mode bit (mode bit 0) becomes set in raw status (offset 0x018) one clock after its event input is sampled high. It stays set after the input returns low.
- R6: In pulse mode, writing a 1 to a bit of offset 0x018 clears that raw status bit. Bits written as 0 are unchanged.
- R7: If a pulse-mode event arrives in the same cycle as a software clear of that bit, the bit stays set.
- R8: A level-mode bit (mode bit 1) takes the value of its event input one clock later. A write of 1 to that bit at offset 0x018 has no effect on it.
- R9: A read of offset 0x020 returns raw status AND enable. Writes to offset 0x020 change nothing.
- R10: `irq_o[n]` is high exactly when page n has a set bit in its masked status.
- R11: Page n starts at byte address n*0x1000. Pages at or beyond `NUM_VINT` read as 0 and ignore writes. Unused offsets inside a page read as 0.
- R12: Offset 0x030 holds the per-bit mode mask (1 = level, 0 = pulse). It is written directly and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (16) | Byte address: page index above bit 12, offset below |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid the cycle after a read request |
| evt_i | input | NUM_VINT*64 (256) | Event inputs; bit n*64+b belongs to page n, bit b |
| irq_o | output | NUM_VINT (4) | Level-high virtual interrupt per page |

## Verification
The bench aims at these cases:
- Separate set and clear writes with zero bits in the data. A design that treated these as plain register writes would lose the other enables.
- A software clear and a pulse event in the same cycle. If the clear took priority, an interrupt would be lost.
- A clear written to a level-mode bit while its source is still high. A design that obeyed that clear would drop a live request.
- A write to an address past the last page. If the decoder dropped the top address bits, that write would alias onto page 1 and change its enable mask.
- A write to the masked view. If that view were decoded as a second clear port, the write would wipe the raw status.

// File: rtl/vint_bank_pkg.sv
package vint_bank_pkg;
  localparam int OFF_EN_SET = 'h000;
  localparam int OFF_EN_CLR = 'h008;
  localparam int OFF_RAW    = 'h018;
  localparam int OFF_MASKED = 'h020;
  localparam int OFF_MODE   = 'h030;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_EN,
    FLD_RAW,
    FLD_MASKED,
    FLD_MODE
  } rd_fld_e;
endpackage

// File: rtl/vint_reg_dec.sv
module vint_reg_dec
  import vint_bank_pkg::*;
#(
  parameter int NUM_VINT = 4,
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 12
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_VINT-1:0] page_o,
  output rd_fld_e             fld_o,
  output logic                set_o,
  output logic                clr_o,
  output logic                ack_o,
  output logic                mode_o
);
  localparam int PIDX_W = ADDR_W - PAGE_LSB;

  logic [PIDX_W-1:0]   page_idx;
  logic [PAGE_LSB-1:0] offset;
  logic                in_range;
  logic                wr;

  assign page_idx = addr_i[ADDR_W-1:PAGE_LSB];
  assign offset   = addr_i[PAGE_LSB-1:0];
  assign in_range = {1'b0, page_idx} < (PIDX_W+1)'(NUM_VINT);
  assign wr       = req_i && we_i && in_range;

  for (genvar i = 0; i < NUM_VINT; i++) begin : g_sel
    assign page_o[i] = in_range && (page_idx == PIDX_W'(i));
  end

  always_comb begin
    fld_o = FLD_NONE;
    if (in_range) begin
      if (offset == PAGE_LSB'(OFF_EN_SET) || offset == PAGE_LSB'(OFF_EN_CLR))
        fld_o = FLD_EN;
      else if (offset == PAGE_LSB'(OFF_RAW))    fld_o = FLD_RAW;
      else if (offset == PAGE_LSB'(OFF_MASKED)) fld_o = FLD_MASKED;
      else if (offset == PAGE_LSB'(OFF_MODE))   fld_o = FLD_MODE;
    end
  end

  assign set_o  = wr && offset == PAGE_LSB'(OFF_EN_SET);
  assign clr_o  = wr && offset == PAGE_LSB'(OFF_EN_CLR);
  assign ack_o  = wr && offset == PAGE_LSB'(OFF_RAW);
  assign mode_o = wr && offset == PAGE_LSB'(OFF_MODE);

  // R11: at most one page decoded
  always_comb begin
    a_r11_page_onehot: assert ($onehot0(page_o));
  end
endmodule

// File: rtl/vint_page.sv
module vint_page #(
  parameter int EVT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             ack_i,
  input  logic             mode_i,
  input  logic [EVT_W-1:0] wdata_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [EVT_W-1:0] en_o,
  output logic [EVT_W-1:0] raw_o,
  output logic [EVT_W-1:0] mode_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] en_q, raw_q, mode_q;
  logic [EVT_W-1:0] set_m, clr_m, ack_m, raw_d;

  assign set_m = (sel_i && set_i) ? wdata_i : '0;
  assign clr_m = (sel_i && clr_i) ? wdata_i : '0;
  assign ack_m = (sel_i && ack_i) ? wdata_i : '0;

  // level bits copy the source; pulse bits latch, new events beat acks
  assign raw_d = (mode_q & evt_i) | (~mode_q & ((raw_q & ~ack_m) | evt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      raw_q  <= '0;
      mode_q <= '0;
    end else begin
      en_q  <= (en_q | set_m) & ~clr_m;
      raw_q <= raw_d;
      if (sel_i && mode_i) mode_q <= wdata_i;
    end
  end

  assign en_o   = en_q;
  assign raw_o  = raw_q;
  assign mode_o = mode_q;
  assign irq_o  = |(raw_q & en_q);

  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && set_i) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  a_r3_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && clr_i) |=> ((en_q & $past(wdata_i)) == '0));

  a_r5_pulse_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & ~mode_q)) |=> ((raw_q & $past(evt_i & ~mode_q)) == $past(evt_i & ~mode_q)));

  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && ack_i) |=> ((raw_q & $past(wdata_i & ~mode_q & ~evt_i)) == '0));

  a_r8_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(mode_q)) == ($past(evt_i) & $past(mode_q))));

  a_r10_no_irq_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/vint_bank.sv
module vint_bank
  import vint_bank_pkg::*;
#(
  parameter int NUM_VINT = 4,
  parameter int EVT_W    = 64,
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [EVT_W-1:0]          wdata_i,
  output logic [EVT_W-1:0]          rdata_o,
  input  logic [NUM_VINT*EVT_W-1:0] evt_i,
  output logic [NUM_VINT-1:0]       irq_o
);
  logic [NUM_VINT-1:0]            page_sel;
  rd_fld_e                        fld;
  logic                           set_s, clr_s, ack_s, mode_s;
  logic [NUM_VINT-1:0][EVT_W-1:0] en_a, raw_a, mode_a;
  logic [EVT_W-1:0]               rd_val;

  vint_reg_dec #(
    .NUM_VINT(NUM_VINT), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)
  ) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .page_o(page_sel),
    .fld_o (fld),
    .set_o (set_s),
    .clr_o (clr_s),
    .ack_o (ack_s),
    .mode_o(mode_s)
  );

  for (genvar i = 0; i < NUM_VINT; i++) begin : g_page
    vint_page #(.EVT_W(EVT_W)) u_page (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (page_sel[i]),
      .set_i  (set_s),
      .clr_i  (clr_s),
      .ack_i  (ack_s),
      .mode_i (mode_s),
      .wdata_i(wdata_i),
      .evt_i  (evt_i[i*EVT_W +: EVT_W]),
      .en_o   (en_a[i]),
      .raw_o  (raw_a[i]),
      .mode_o (mode_a[i]),
      .irq_o  (irq_o[i])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_VINT; i++) begin
      if (page_sel[i]) begin
        unique case (fld)
          FLD_EN:     rd_val = en_a[i];
          FLD_RAW:    rd_val = raw_a[i];
          FLD_MASKED: rd_val = raw_a[i] & en_a[i];
          FLD_MODE:   rd_val = mode_a[i];
          default:    rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_val;
  end

  a_r11_oob_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && page_sel == '0) |=> (rdata_o == '0));
endmodule

// File: tb/tb_vint_bank.sv
module tb_vint_bank;
  localparam int NV = 4;
  localparam int EW = 64;
  localparam int AW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [EW-1:0]     wdata = '0;
  logic [EW-1:0]     rdata;
  logic [NV*EW-1:0]  evt = '0;
  logic [NV-1:0]     irq;

  int checks = 0, failures = 0;
  logic rd_seen = 1'b0;
  logic done = 1'b0;
  logic [EW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  vint_bank #(.NUM_VINT(NV), .EVT_W(EW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  always @(posedge clk) rd_seen <= req && !we;

  // monitor: compare read data against queued expectations
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [EW-1:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [EW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [EW-1:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic chk_irq(input int n, input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq[n] !== e) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", t, irq[n], e);
    end
  endtask

  task automatic pulse(input int v, input int b);
    @(negedge clk); evt[v*EW+b] = 1'b1;
    @(negedge clk); evt[v*EW+b] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(16'h0000, 64'h0, "R1 enable");
    rd(16'h0018, 64'h0, "R1 raw");
    rd(16'h0020, 64'h0, "R1 masked");
    rd(16'h0030, 64'h0, "R1 mode");
    chk_irq(0, 1'b0, "R1 irq0");

    // R2, R3, R4 on page 1
    wr(16'h1000, 64'h5);
    wr(16'h1000, 64'h8);
    rd(16'h1008, 64'hD, "R4 read via clr offset");
    rd(16'h1000, 64'hD, "R2 set keeps zeros");
    wr(16'h1008, 64'h4);
    rd(16'h1000, 64'h9, "R3 clear one bit");

    // R5 pulse latch, R10 irq
    pulse(1, 0);
    rd(16'h1018, 64'h1, "R5 latched after drop");
    rd(16'h1020, 64'h1, "R9 masked");
    chk_irq(1, 1'b1, "R10 irq on");

    // R9 masked view excludes disabled bit, writes ignored
    pulse(1, 1);
    rd(16'h1018, 64'h3, "R5 second bit");
    rd(16'h1020, 64'h1, "R9 masked excludes disabled");
    wr(16'h1020, '1);
    rd(16'h1018, 64'h3, "R9 write to masked ignored raw");
    rd(16'h1000, 64'h9, "R9 write to masked ignored en");

    // R6 ack
    wr(16'h1018, 64'h1);
    rd(16'h1018, 64'h2, "R6 ack one bit");
    chk_irq(1, 1'b0, "R10 irq off");
    wr(16'h1018, 64'h2);
    rd(16'h1018, 64'h0, "R6 ack second bit");

    // R7 event and clear in same cycle
    @(negedge clk);
    evt[EW+1] = 1'b1;
    req = 1'b1; we = 1'b1; addr = 16'h1018; wdata = 64'h2;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
    @(negedge clk); evt[EW+1] = 1'b0;
    rd(16'h1018, 64'h2, "R7 event wins");
    wr(16'h1018, 64'h2);

    // R12 mode, R8 level
    wr(16'h1030, 64'h8);
    rd(16'h1030, 64'h8, "R12 mode readback");
    @(negedge clk); evt[EW+3] = 1'b1;
    rd(16'h1018, 64'h8, "R8 level follows high");
    chk_irq(1, 1'b1, "R10 level irq");
    wr(16'h1018, 64'h8);
    rd(16'h1018, 64'h8, "R8 ack ignored");
    @(negedge clk); evt[EW+3] = 1'b0;
    rd(16'h1018, 64'h0, "R8 level drops");
    chk_irq(1, 1'b0, "R10 level irq off");

    // R11 paging
    rd(16'h0000, 64'h0, "R11 page0 untouched");
    pulse(0, 63);
    rd(16'h0018, 64'h8000_0000_0000_0000, "R11 page0 bit63");
    chk_irq(0, 1'b0, "R10 page0 masked");
    rd(16'h1018, 64'h0, "R11 page1 isolated");
    wr(16'h0000, 64'h8000_0000_0000_0000);
    chk_irq(0, 1'b1, "R10 page0 irq");
    wr(16'h5000, 64'hF0);
    rd(16'h5000, 64'h0, "R11 oob read");
    rd(16'h1000, 64'h9, "R11 oob write no alias");
    rd(16'h1010, 64'h0, "R11 unused offset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule